// File: doc/BRIEF.md
# In-Order Retire Queue

This block keeps track of in-flight instructions in a circular queue of slots and releases them in program order. On the dispatch side, a request asks for a run of consecutive slots for one instruction. When the run fits, the block hands back the index of its first slot; that index is the token the instruction carries. On the execute side, a notification that names a token marks that instruction as finished.

Each cycle the retire side starts at the oldest token and releases finished tokens one after another. It stops at the first token that has not finished, or when it reaches the per-cycle limit. Released instruction identifiers leave through a set of lanes with valid strobes, oldest first. The queue depth is set by a parameter. A second parameter caps how many tokens can retire in one cycle, and a value of zero removes the cap.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: `q_empty` is 1, `q_full` is 0, `free_slots` equals DEPTH, no `ret_valid` bit is set and `rsv_stall` is 0.
- R2: A request of N slots with 1 <= N <= `free_slots` is accepted in the cycle it is presented. `rsv_token` then shows the first slot index of the new token. The next token starts N slots further on, wrapping modulo DEPTH.
- R3: A request of zero slots, or of more slots than `free_slots` shows, raises `rsv_stall` in that cycle and is dropped. Queue contents and the next token index stay unchanged.
- R4: An execute notification for a live token's first slot marks that token finished. The earliest cycle in which it can retire is the one after the notification.
- R5: Retirement starts at the oldest token and proceeds strictly in order. It stops at the first token that has not finished, even if younger tokens have finished.
- R6: With MAX_RETIRE > 0, at most MAX_RETIRE tokens retire per cycle, on lanes 0 upward in program order. Lane k carries its identifier on `ret_id[k*ID_W +: ID_W]`, and the set `ret_valid` bits are always contiguous from bit 0.
- R7: With MAX_RETIRE = 0 there is no cap, and every finished token in the unbroken run from the oldest retires in the same cycle.
- R8: Retiring a token moves the oldest position forward by that token's slot count, modulo DEPTH. The freed slots appear in `free_slots` one cycle later, together with any reservation made in the same cycle. A request is judged against the free count from before that cycle's retirements.
- R9: `q_empty` is 1 exactly when `free_slots` equals DEPTH, and `q_full` is 1 exactly when `free_slots` is 0. An empty queue retires nothing.
- R10: An execute notification that names a free slot, or a slot inside a token other than its first, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_slots | input | CNT_W | Number of slots requested |
| rsv_id | input | ID_W | Instruction identifier stored with the token |
| rsv_stall | output | 1 | Request refused this cycle |
| rsv_token | output | IDX_W | First slot index given to an accepted request |
| exe_valid | input | 1 | Execute notification |
| exe_token | input | IDX_W | Token index being marked finished |
| ret_valid | output | RET_LANES | Retire strobes, bit 0 oldest |
| ret_id | output | RET_LANES*ID_W | Retired identifiers, lane k at bits k*ID_W |
| q_empty | output | 1 | No slot in use |
| q_full | output | 1 | No slot free |
| free_slots | output | CNT_W | Number of free slots |

## Verification
A reservation and a retirement can fall in the same cycle, and they compete for the same free-slot count. To provoke this, the queue is filled to the last slot, the oldest tokens are marked finished, and a further request is presented in the very cycle they retire. The request must be refused, because it is judged against the count from before the retirement. The same request must then be accepted one cycle later, when `free_slots` has grown by the retired slot counts. A reference queue model in the bench predicts the stall, the token, the retire lanes and the counts for a capped and an uncapped instance every cycle.

// File: rtl/rcq_pkg.sv
package rcq_pkg;

   typedef enum logic [0:0] {
      WALK_CAPPED = 1'b0,
      WALK_OPEN   = 1'b1
   } walk_mode_e;

   function automatic walk_mode_e mode_of(int cap);
      return (cap == 0) ? WALK_OPEN : WALK_CAPPED;
   endfunction

   function automatic int lane_count(int depth, int cap);
      return (cap == 0 || cap > depth) ? depth : cap;
   endfunction

   // idx < depth and n <= depth, so one subtraction is enough
   function automatic int wrap_idx(int idx, int n, int depth);
      int s;
      s = idx + n;
      if (s >= depth) s = s - depth;
      return s;
   endfunction

endpackage

// File: rtl/rcq_alloc.sv
module rcq_alloc
   import rcq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rsv_valid,
   input  logic [CNT_W-1:0] rsv_slots,
   input  logic [CNT_W-1:0] ret_slots,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] free_cnt,
   output logic             accept,
   output logic             stall,
   output logic             empty,
   output logic             full
);

   logic [CNT_W-1:0] take;
   logic [CNT_W-1:0] free_nxt;
   logic [IDX_W-1:0] head_nxt;
   logic [IDX_W-1:0] tail_nxt;

   always_comb begin
      accept   = rsv_valid && (rsv_slots != '0) && (rsv_slots <= free_cnt);
      stall    = rsv_valid && !accept;
      take     = accept ? rsv_slots : '0;
      free_nxt = free_cnt - take + ret_slots;
      head_nxt = IDX_W'(wrap_idx(int'(head), int'(ret_slots), DEPTH));
      tail_nxt = IDX_W'(wrap_idx(int'(tail), int'(take), DEPTH));
      empty    = (free_cnt == CNT_W'(DEPTH));
      full     = (free_cnt == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head     <= '0;
         tail     <= '0;
         free_cnt <= CNT_W'(DEPTH);
      end else begin
         head     <= head_nxt;
         tail     <= tail_nxt;
         free_cnt <= free_nxt;
      end
   end

   int gap;
   always_comb begin
      if (tail >= head) gap = int'(tail) - int'(head);
      else              gap = int'(tail) + DEPTH - int'(head);
   end

   // R8
   ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gap == 0) ? (free_cnt == '0 || free_cnt == CNT_W'(DEPTH))
                 : (gap == DEPTH - int'(free_cnt)));

   // R9
   free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/rcq_store.sv
module rcq_store #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5,
   parameter int IDX_W = 4,
   parameter int ID_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [CNT_W-1:0]            wr_slots,
   input  logic [ID_W-1:0]             wr_id,
   input  logic                        exe_en,
   input  logic [IDX_W-1:0]            exe_idx,
   input  logic [DEPTH-1:0]            clr_mask,
   output logic [DEPTH-1:0]            done_vec,
   output logic [DEPTH-1:0][CNT_W-1:0] slots_arr,
   output logic [DEPTH-1:0][ID_W-1:0]  id_arr
);

   logic [DEPTH-1:0] live_vec;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic             live_q;
      logic             done_q;
      logic [CNT_W-1:0] n_q;
      logic [ID_W-1:0]  id_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q <= 1'b0;
            done_q <= 1'b0;
            n_q    <= '0;
            id_q   <= '0;
         end else if (clr_mask[i]) begin
            live_q <= 1'b0;
            done_q <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            live_q <= 1'b1;
            done_q <= 1'b0;
            n_q    <= wr_slots;
            id_q   <= wr_id;
         end else if (exe_en && exe_idx == IDX_W'(i) && live_q) begin
            done_q <= 1'b1;
         end
      end

      assign live_vec[i]  = live_q;
      assign done_vec[i]  = done_q;
      assign slots_arr[i] = n_q;
      assign id_arr[i]    = id_q;
   end

   // R2
   rsv_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !live_vec[wr_idx]);

   // R4
   exe_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exe_en && live_vec[exe_idx] && !clr_mask[exe_idx]) |=> done_vec[$past(exe_idx)]);

   // R5
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask & ~(done_vec & live_vec)) == '0);

endmodule

// File: rtl/rcq_walk.sv
module rcq_walk
   import rcq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5,
   parameter int IDX_W = 4,
   parameter int ID_W  = 8,
   parameter int LANES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            head,
   input  logic [CNT_W-1:0]            free_cnt,
   input  logic [DEPTH-1:0]            done_vec,
   input  logic [DEPTH-1:0][CNT_W-1:0] slots_arr,
   input  logic [DEPTH-1:0][ID_W-1:0]  id_arr,
   output logic [LANES-1:0]            ret_valid,
   output logic [LANES-1:0][ID_W-1:0]  ret_id,
   output logic [CNT_W-1:0]            ret_slots,
   output logic [DEPTH-1:0]            clr_mask
);

   logic [IDX_W-1:0] idx;
   int               walked;
   int               used;
   logic             go;

   always_comb begin
      idx       = head;
      walked    = 0;
      used      = DEPTH - int'(free_cnt);
      go        = 1'b1;
      clr_mask  = '0;
      ret_valid = '0;
      ret_id    = '0;
      for (int k = 0; k < LANES; k++) begin
         go = go && (walked < used) && done_vec[idx];
         if (go) begin
            ret_valid[k]  = 1'b1;
            ret_id[k]     = id_arr[idx];
            clr_mask[idx] = 1'b1;
            walked        = walked + int'(slots_arr[idx]);
            idx           = IDX_W'(wrap_idx(int'(idx), int'(slots_arr[idx]), DEPTH));
         end
      end
      ret_slots = CNT_W'(walked);
   end

   // R6
   ret_in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({1'b0, ret_valid} + {{LANES{1'b0}}, 1'b1}));

   // R8
   ret_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ret_slots) <= DEPTH - int'(free_cnt));

endmodule

// File: rtl/retire_queue.sv
module retire_queue
   import rcq_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int MAX_RETIRE = 2,
   parameter int ID_W       = 8,
   localparam int CNT_W     = $clog2(DEPTH + 1),
   localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int RET_LANES = lane_count(DEPTH, MAX_RETIRE)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rsv_valid,
   input  logic [CNT_W-1:0]          rsv_slots,
   input  logic [ID_W-1:0]           rsv_id,
   output logic                      rsv_stall,
   output logic [IDX_W-1:0]          rsv_token,
   input  logic                      exe_valid,
   input  logic [IDX_W-1:0]          exe_token,
   output logic [RET_LANES-1:0]      ret_valid,
   output logic [RET_LANES*ID_W-1:0] ret_id,
   output logic                      q_empty,
   output logic                      q_full,
   output logic [CNT_W-1:0]          free_slots
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("retire_queue: DEPTH must be at least 2");
   end
   if (MAX_RETIRE < 0 || MAX_RETIRE > DEPTH) begin : g_bad_cap
      $error("retire_queue: MAX_RETIRE must lie in 0..DEPTH");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("retire_queue: ID_W must be positive");
   end

   logic [IDX_W-1:0]                head;
   logic [IDX_W-1:0]                tail;
   logic                            accept;
   logic [CNT_W-1:0]                ret_slots;
   logic [DEPTH-1:0]                clr_mask;
   logic [DEPTH-1:0]                done_vec;
   logic [DEPTH-1:0][CNT_W-1:0]     slots_arr;
   logic [DEPTH-1:0][ID_W-1:0]      id_arr;
   logic [RET_LANES-1:0][ID_W-1:0]  ret_id_lanes;

   rcq_alloc #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .rsv_valid (rsv_valid),
      .rsv_slots (rsv_slots),
      .ret_slots (ret_slots),
      .head      (head),
      .tail      (tail),
      .free_cnt  (free_slots),
      .accept    (accept),
      .stall     (rsv_stall),
      .empty     (q_empty),
      .full      (q_full)
   );

   rcq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .ID_W(ID_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (accept),
      .wr_idx    (tail),
      .wr_slots  (rsv_slots),
      .wr_id     (rsv_id),
      .exe_en    (exe_valid),
      .exe_idx   (exe_token),
      .clr_mask  (clr_mask),
      .done_vec  (done_vec),
      .slots_arr (slots_arr),
      .id_arr    (id_arr)
   );

   if (mode_of(MAX_RETIRE) == WALK_OPEN) begin : g_open
      rcq_walk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .ID_W(ID_W),
                 .LANES(DEPTH)) u_walk (
         .clk       (clk),
         .rst_n     (rst_n),
         .head      (head),
         .free_cnt  (free_slots),
         .done_vec  (done_vec),
         .slots_arr (slots_arr),
         .id_arr    (id_arr),
         .ret_valid (ret_valid),
         .ret_id    (ret_id_lanes),
         .ret_slots (ret_slots),
         .clr_mask  (clr_mask)
      );
   end else begin : g_capped
      rcq_walk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .ID_W(ID_W),
                 .LANES(MAX_RETIRE)) u_walk (
         .clk       (clk),
         .rst_n     (rst_n),
         .head      (head),
         .free_cnt  (free_slots),
         .done_vec  (done_vec),
         .slots_arr (slots_arr),
         .id_arr    (id_arr),
         .ret_valid (ret_valid),
         .ret_id    (ret_id_lanes),
         .ret_slots (ret_slots),
         .clr_mask  (clr_mask)
      );
   end

   assign ret_id    = ret_id_lanes;
   assign rsv_token = tail;

   // R9
   empty_no_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty |-> (ret_valid == '0));

   // R3
   stall_keeps_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_stall |=> (rsv_token == $past(rsv_token)));

endmodule

// File: tb/retire_queue_tb.sv
`timescale 1ns/1ps
module retire_queue_tb;

   localparam int D  = 8;
   localparam int IW = 8;

   typedef struct packed {
      logic       rv;
      logic [3:0] rn;
      logic [7:0] rid;
      logic       ev;
      logic [2:0] et;
   } row_t;

   localparam int NROWS = 26;
   localparam row_t ROWS [NROWS] = '{
      '{1'b1, 4'd3, 8'h11, 1'b0, 3'd0},  // R2 three-slot token
      '{1'b1, 4'd1, 8'h12, 1'b0, 3'd0},
      '{1'b1, 4'd2, 8'h13, 1'b0, 3'd0},
      '{1'b1, 4'd2, 8'h14, 1'b0, 3'd0},  // R9 now full
      '{1'b1, 4'd1, 8'h15, 1'b0, 3'd0},  // R3 refused
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd3},  // R5 younger finishes first
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd1},  // R10 inner slot
      '{1'b0, 4'd0, 8'h00, 1'b0, 3'd0},
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd0},  // R4 oldest finishes
      '{1'b1, 4'd3, 8'h16, 1'b0, 3'd0},  // R8 request during retire
      '{1'b1, 4'd3, 8'h16, 1'b0, 3'd0},
      '{1'b1, 4'd1, 8'h17, 1'b1, 3'd6},
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd4},
      '{1'b1, 4'd4, 8'h18, 1'b0, 3'd0},
      '{1'b1, 4'd4, 8'h18, 1'b0, 3'd0},  // R2 wraps
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd4},
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd3},
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd0},
      '{1'b0, 4'd0, 8'h00, 1'b0, 3'd0},  // R6 and R7 differ here
      '{1'b0, 4'd0, 8'h00, 1'b0, 3'd0},
      '{1'b1, 4'd0, 8'h20, 1'b0, 3'd0},  // R3 zero slots
      '{1'b1, 4'd9, 8'h21, 1'b0, 3'd0},  // R3 too many
      '{1'b1, 4'd8, 8'h22, 1'b0, 3'd0},  // R2 whole queue
      '{1'b0, 4'd0, 8'h00, 1'b1, 3'd0},
      '{1'b0, 4'd0, 8'h00, 1'b0, 3'd0},
      '{1'b0, 4'd0, 8'h00, 1'b0, 3'd0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rsv_valid = 1'b0;
   logic [3:0]      rsv_slots = '0;
   logic [IW-1:0]   rsv_id = '0;
   logic            exe_valid = 1'b0;
   logic [2:0]      exe_token = '0;

   logic            a_stall, b_stall;
   logic [2:0]      a_tok, b_tok;
   logic [1:0]      a_rv;
   logic [7:0]      b_rv;
   logic [2*IW-1:0] a_id;
   logic [8*IW-1:0] b_id;
   logic            a_emp, b_emp, a_full, b_full;
   logic [3:0]      a_free, b_free;

   always #2 clk = ~clk;

   retire_queue #(.DEPTH(D), .MAX_RETIRE(2), .ID_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_slots(rsv_slots),
      .rsv_id(rsv_id), .rsv_stall(a_stall), .rsv_token(a_tok),
      .exe_valid(exe_valid), .exe_token(exe_token), .ret_valid(a_rv),
      .ret_id(a_id), .q_empty(a_emp), .q_full(a_full), .free_slots(a_free));

   retire_queue #(.DEPTH(D), .MAX_RETIRE(0), .ID_W(IW)) u_dut_unl (
      .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_slots(rsv_slots),
      .rsv_id(rsv_id), .rsv_stall(b_stall), .rsv_token(b_tok),
      .exe_valid(exe_valid), .exe_token(exe_token), .ret_valid(b_rv),
      .ret_id(b_id), .q_empty(b_emp), .q_full(b_full), .free_slots(b_free));

   int n_chk = 0;
   int n_bad = 0;

   int m_head [2];
   int m_tail [2];
   int m_free [2];
   bit m_live [2][D];
   bit m_done [2][D];
   int m_n    [2][D];
   int m_id   [2][D];

   task automatic chk(int got, int exp, string what);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", what, got, exp, $time);
      end
   endtask

   task automatic run_unit(int u, int cap, bit g_stall, int g_tok,
                           logic [7:0] g_rv, logic [63:0] g_id,
                           int g_free, bit g_emp, bit g_full);
      int idx, walked, used, k, lanes, rn;
      bit exp_stall, acc;
      bit clr [D];
      idx    = m_head[u];
      walked = 0;
      used   = D - m_free[u];
      k      = 0;
      lanes  = (cap == 0) ? D : cap;
      rn     = int'(rsv_slots);
      for (int i = 0; i < D; i++) clr[i] = 1'b0;
      while (k < lanes && walked < used && m_done[u][idx]) begin
         chk(int'(g_id[k*IW +: IW]), m_id[u][idx], "R5/R6/R7 retired id");
         clr[idx] = 1'b1;
         walked   = walked + m_n[u][idx];
         idx      = (idx + m_n[u][idx]) % D;
         k++;
      end
      chk(int'(g_rv), (1 << k) - 1, "R4/R5/R6/R7/R10 retire strobes");
      exp_stall = rsv_valid && (rn == 0 || rn > m_free[u]);
      chk(int'(g_stall), int'(exp_stall), "R2/R3 stall");
      acc = rsv_valid && !exp_stall;
      if (acc) chk(g_tok, m_tail[u], "R2 token");
      chk(g_free, m_free[u], "R8 free count");
      chk(int'(g_emp), int'(m_free[u] == D), "R9 empty");
      chk(int'(g_full), int'(m_free[u] == 0), "R9 full");
      // state update at the coming edge
      if (exe_valid && m_live[u][exe_token] && !clr[exe_token])
         m_done[u][exe_token] = 1'b1;
      for (int i = 0; i < D; i++)
         if (clr[i]) begin
            m_live[u][i] = 1'b0;
            m_done[u][i] = 1'b0;
         end
      if (acc) begin
         m_live[u][m_tail[u]] = 1'b1;
         m_done[u][m_tail[u]] = 1'b0;
         m_n[u][m_tail[u]]    = rn;
         m_id[u][m_tail[u]]   = int'(rsv_id);
         m_tail[u] = (m_tail[u] + rn) % D;
      end
      m_free[u] = m_free[u] - (acc ? rn : 0) + walked;
      m_head[u] = idx;
   endtask

   task automatic step_both();
      run_unit(0, 2, a_stall, int'(a_tok), {6'b0, a_rv}, {48'b0, a_id},
               int'(a_free), a_emp, a_full);
      run_unit(1, 0, b_stall, int'(b_tok), b_rv, b_id,
               int'(b_free), b_emp, b_full);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int u = 0; u < 2; u++) begin
         m_head[u] = 0;
         m_tail[u] = 0;
         m_free[u] = D;
         for (int i = 0; i < D; i++) begin
            m_live[u][i] = 1'b0;
            m_done[u][i] = 1'b0;
            m_n[u][i]    = 0;
            m_id[u][i]   = 0;
         end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state on both instances
      chk(int'(a_free), D, "R1 free after reset");
      chk(int'(a_emp), 1, "R1 empty after reset");
      chk(int'(a_full), 0, "R1 full after reset");
      chk(int'(a_rv), 0, "R1 no retire after reset");
      chk(int'(a_stall), 0, "R1 no stall after reset");
      chk(int'(b_free), D, "R1 free after reset");
      chk(int'(b_rv), 0, "R1 no retire after reset");

      for (int r = 0; r < NROWS; r++) begin
         @(negedge clk);
         rsv_valid = ROWS[r].rv;
         rsv_slots = ROWS[r].rn;
         rsv_id    = ROWS[r].rid;
         exe_valid = ROWS[r].ev;
         exe_token = ROWS[r].et;
         #1;
         step_both();
      end

      // directed: R10 notification on a free slot, then drain
      @(negedge clk);
      rsv_valid = 1'b0;
      exe_valid = 1'b1;
      exe_token = 3'd5;
      #1;
      step_both();
      for (int r = 0; r < 3; r++) begin
         @(negedge clk);
         exe_valid = 1'b0;
         #1;
         step_both();
      end
      chk(int'(a_emp), 1, "R9 empty after drain");
      chk(int'(b_emp), 1, "R9 empty after drain");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule